// File: doc/BRIEF.md
# LCD Segment Blink Controller

This block sits between the segment data latch of a segment-LCD driver and its output stage and makes chosen pixels blink. A blink phase is derived from the display's segment clock tick. While the phase is in its dark half, the segments picked by the blink scope are forced low before they reach the pads. In the lit half, and for any segment outside the scope, the data passes unchanged.

The scope ranges from nothing (plain pass-through), to a single pixel (segment line 0 while common 0 is driven), to segment line 0 on every common, to the whole display. A three-bit rate select sets the full blink period to 8, 16, 32, 64, 128, 256, 512 or 1024 segment ticks. Any change of scope or rate restarts the blink at the start of a lit half. Frame sequencing and clock generation belong to the surrounding driver.

Top module: `lcdblk_ctrl`

## Requirements
- R1: With scope code 0, `seg_out` equals `seg_in` on every cycle.
- R2: With scope code 1, only bit 0 may be forced low, and only while `com_idx` is 0. Every other bit, and bit 0 on any other common, passes unchanged.
- R3: With scope code 2, only bit 0 may be forced low, on any value of `com_idx`. Bits 31..1 pass unchanged.
- R4: With scope code 3, all 32 bits are forced low during the dark half.
- R5: With rate select s, the full blink period is 8·2^s ticks. After a restart, a phase of (4·2^s) ticks is lit, then a phase of the same length is dark, and the pattern repeats. The dark state after k ticks is floor(k / (4·2^s)) mod 2.
- R6: The blink phase moves only on cycles with `tick` high. A cycle with `tick` low leaves the phase unchanged.
- R7: In the cycle in which `scope` or `rate_sel` differs from its value in the previous cycle, the output is lit (`seg_out` equals `seg_in`). The tick count then restarts from zero.
- R8: Blinking only clears bits: `seg_out` never has a 1 where `seg_in` has a 0.
- R9: During and directly after reset, the phase is lit and the tick count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per segment-clock period |
| scope | input | 2 | Blink scope: 0 off, 1 one pixel, 2 segment 0 on all commons, 3 all |
| rate_sel | input | 3 | Blink period select, period = 8·2^rate_sel ticks |
| com_idx | input | 3 | Index of the common currently driven |
| seg_in | input | 32 | Segment data for the current common |
| seg_out | output | 32 | Segment data after blink masking |

## Verification
The bound checker watches the per-cycle properties on every cycle: pass-through with scope 0, which bits each scope may clear, that blinking never sets a bit, the lit output in a configuration-change cycle, and that the phase holds on cycles without a tick. The checker cannot show the exact half-period length for each rate select or the on/off sequence after a restart, because these span hundreds of cycles. The bench sweeps every scope against every rate select and compares each output with an arithmetic model of the tick count. This covers idle cycles, changing common indexes, and restarts from the dark half.

// File: rtl/lcdblk_pkg.sv
package lcdblk_pkg;

   typedef enum logic [1:0] {
      BLK_NONE   = 2'd0,
      BLK_PIXEL  = 2'd1,
      BLK_COLUMN = 2'd2,
      BLK_ALL    = 2'd3
   } blk_scope_e;

endpackage

// File: rtl/lcdblk_timer.sv
module lcdblk_timer
   import lcdblk_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3,
   parameter int CNT_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       scope,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             phase_off_o,
   output logic             blank_o
);

   localparam int HALF_LOG2_MIN = BASE_LOG2 - 1;
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic [1:0]       scope_q;
   logic [SEL_W-1:0] rate_q;
   logic             cfg_chg;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             off_q;

   // last count value of one half period: 2^(HALF_LOG2_MIN+rate_sel) - 1
   always_comb begin
      term    = ALL_ONES >> (CNT_W - HALF_LOG2_MIN - int'(rate_sel));
      cfg_chg = (scope != scope_q) || (rate_sel != rate_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scope_q <= BLK_NONE;
         rate_q  <= '0;
         cnt_q   <= '0;
         off_q   <= 1'b0;
      end else begin
         scope_q <= scope;
         rate_q  <= rate_sel;
         if (cfg_chg) begin
            cnt_q <= '0;
            off_q <= 1'b0;
         end else if (tick) begin
            if (cnt_q == term) begin
               cnt_q <= '0;
               off_q <= ~off_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign phase_off_o = off_q;
   // a config change forces the lit half in the same cycle
   assign blank_o     = off_q & ~cfg_chg;

endmodule

// File: rtl/lcdblk_mask.sv
module lcdblk_mask
   import lcdblk_pkg::*;
#(
   parameter int SEG_W = 32,
   parameter int COM_W = 3
) (
   input  logic [1:0]       scope,
   input  logic [COM_W-1:0] com_idx,
   input  logic             blank,
   input  logic [SEG_W-1:0] seg_in,
   output logic [SEG_W-1:0] seg_out
);

   logic first_com;
   assign first_com = (com_idx == '0);

   for (genvar i = 0; i < SEG_W; i++) begin : g_seg
      logic hit;
      if (i == 0) begin : g_lead
         always_comb begin
            unique case (scope)
               BLK_PIXEL:  hit = first_com;
               BLK_COLUMN: hit = 1'b1;
               BLK_ALL:    hit = 1'b1;
               default:    hit = 1'b0;
            endcase
         end
      end else begin : g_rest
         assign hit = (scope == BLK_ALL);
      end
      assign seg_out[i] = seg_in[i] & ~(blank & hit);
   end

endmodule

// File: rtl/lcdblk_ctrl.sv
module lcdblk_ctrl
   import lcdblk_pkg::*;
#(
   parameter int SEG_W     = 32,
   parameter int COM_W     = 3,
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [1:0]       scope,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic [COM_W-1:0] com_idx,
   input  logic [SEG_W-1:0] seg_in,
   output logic [SEG_W-1:0] seg_out
);

   localparam int CNT_W = BASE_LOG2 - 1 + (1 << SEL_W) - 1;

   if (SEG_W < 2) begin : g_bad_seg
      $error("lcdblk_ctrl: SEG_W must be at least 2");
   end
   if (BASE_LOG2 < 2) begin : g_bad_base
      $error("lcdblk_ctrl: BASE_LOG2 must be at least 2");
   end
   if (SEL_W < 1 || CNT_W > 30) begin : g_bad_sel
      $error("lcdblk_ctrl: SEL_W out of range");
   end

   logic phase_off;
   logic blank;

   lcdblk_timer #(
      .SEL_W     (SEL_W),
      .BASE_LOG2 (BASE_LOG2),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .scope       (scope),
      .rate_sel    (rate_sel),
      .phase_off_o (phase_off),
      .blank_o     (blank)
   );

   lcdblk_mask #(
      .SEG_W (SEG_W),
      .COM_W (COM_W)
   ) u_mask (
      .scope   (scope),
      .com_idx (com_idx),
      .blank   (blank),
      .seg_in  (seg_in),
      .seg_out (seg_out)
   );

endmodule

// File: rtl/lcdblk_ctrl_chk.sv
module lcdblk_ctrl_chk #(
   parameter int SEG_W = 32,
   parameter int COM_W = 3,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [1:0]       scope,
   input logic [SEL_W-1:0] rate_sel,
   input logic [COM_W-1:0] com_idx,
   input logic [SEG_W-1:0] seg_in,
   input logic [SEG_W-1:0] seg_out,
   input logic             phase_off
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_pass_scope0_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (scope == 2'd0) |-> (seg_out == seg_in));

   p_pixel_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scope == 2'd1) |-> (seg_out[SEG_W-1:1] == seg_in[SEG_W-1:1])
                          && (com_idx == '0 || seg_out[0] == seg_in[0]));

   p_column_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (scope == 2'd2) |-> (seg_out[SEG_W-1:1] == seg_in[SEG_W-1:1]));

   p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !tick && scope == $past(scope) && rate_sel == $past(rate_sel))
      |=> $stable(phase_off));

   p_lit_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (scope != $past(scope) || rate_sel != $past(rate_sel)))
      |-> (seg_out == seg_in));

   p_clear_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((seg_out & ~seg_in) == '0));

endmodule

bind lcdblk_ctrl lcdblk_ctrl_chk #(
   .SEG_W (SEG_W),
   .COM_W (COM_W),
   .SEL_W (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .scope     (scope),
   .rate_sel  (rate_sel),
   .com_idx   (com_idx),
   .seg_in    (seg_in),
   .seg_out   (seg_out),
   .phase_off (phase_off)
);

// File: tb/lcdblk_ctrl_tb.sv
module lcdblk_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  scope = 2'd0;
   logic [2:0]  rate_sel = 3'd0;
   logic [2:0]  com_idx = 3'd0;
   logic [31:0] seg_in = 32'd0;
   logic [31:0] seg_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lcdblk_ctrl dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .scope    (scope),
      .rate_sel (rate_sel),
      .com_idx  (com_idx),
      .seg_in   (seg_in),
      .seg_out  (seg_out)
   );

   function automatic logic [31:0] model(input logic [31:0] d, input int c,
                                         input int m, input bit dark);
      logic [31:0] msk;
      if (m == 3)                 msk = 32'hFFFF_FFFF;
      else if (m == 2)            msk = 32'h1;
      else if (m == 1 && c == 0)  msk = 32'h1;
      else                        msk = 32'h0;
      return dark ? (d & ~msk) : d;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h (scope=%0d rate=%0d com=%0d)",
                  req, act, exp, scope, rate_sel, com_idx);
      end
   endtask

   function automatic string scope_req(input int m);
      case (m)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   // sweep one scope/rate pair, ending in the dark half
   task automatic run_cfg(input int m, input int s);
      int k    = 0;
      int step = 0;
      int half = 4 << s;
      logic [31:0] d;
      @(negedge clk);
      scope    = 2'(m);
      rate_sel = 3'(s);
      tick     = 1'b1;
      seg_in   = 32'hFFFF_FFFF;
      com_idx  = 3'd0;
      #1;
      chk("R7", seg_out, 32'hFFFF_FFFF);   // change cycle is lit
      @(posedge clk);
      while (k < 5 * half + 2) begin
         @(negedge clk);
         tick    = ((step % 7) != 6);
         d       = 32'(32'h9E37_79B9 * (k + 1)) ^ 32'(step << 5);
         seg_in  = d;
         com_idx = 3'(step % 8);
         #1;
         chk(scope_req(m), seg_out, model(d, step % 8, m, ((k / half) % 2) == 1));
         chk("R8", seg_out & ~d, 32'h0);
         if (k == half || k == 2 * half)
            chk("R5", 32'(seg_out == d), 32'(m == 0 || !((k / half) % 2 == 1)
                     || model(d, step % 8, m, 1'b1) == d));
         @(posedge clk);
         if (tick) k++;
         else begin
            // idle tick: phase state read back via all-ones data in the next cycle
            @(negedge clk);
            tick    = 1'b0;
            seg_in  = 32'hFFFF_FFFF;
            com_idx = 3'd0;
            #1;
            chk("R6", seg_out, model(32'hFFFF_FFFF, 0, m, ((k / half) % 2) == 1));
            @(posedge clk);
         end
         step++;
      end
   endtask

   initial begin
      scope   = 2'd0;
      rate_sel = 3'd0;
      seg_in  = 32'hA5A5_5A5A;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", seg_out, 32'hA5A5_5A5A);
      rst_n = 1'b1;
      @(negedge clk);
      scope  = 2'd3;
      seg_in = 32'hFFFF_FFFF;
      tick   = 1'b0;
      #1;
      chk("R9", seg_out, 32'hFFFF_FFFF);
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 8; s++)
            run_cfg(m, s);
      // restart from the dark half by changing only the rate
      run_cfg(3, 1);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule